// File: doc/BRIEF.md
# Carry-Select Adder with Increment Converters

This block is a purely combinational binary adder for two unsigned operands of a configurable width plus a single carry input. It returns a sum of the same width and a carry output. The operand width is cut into equal slices. The lowest slice is an ordinary ripple-carry chain that takes the external carry directly.

Every higher slice works out its result once, assuming no incoming carry, with a single ripple chain. An increment converter then turns that result into the "incoming carry is one" version, including its own carry. A two-way selector picks between the two versions using the carry that comes out of the slice below. Both candidates of a slice are ready before its select line settles, so each slice adds only one selector stage to the carry path.

The block is used wherever a wide addition has to fit into a tight combinational budget and a duplicated ripple chain per slice would cost too much area. The width and the slice size are parameters. Widths of 8, 16, 32 and 64 bits are the intended settings.

Top module: `csel_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the unsigned value a + b + cin, computed at WIDTH+1 bits.
- R2: For fixed operands, raising cin from 0 to 1 raises the (WIDTH+1)-bit result {cout, sum} by exactly one.
- R3: With a all ones, b zero and cin one, sum is zero and cout is one. The increment wraps through every slice.
- R4: With b equal to the bitwise complement of a and cin zero, sum is all ones and cout is zero.
- R5: With b zero and cin zero, sum equals a and cout is zero.
- R6: A carry produced in any slice reaches the next slice through its selector. With a low slice all ones and b equal to one, sum equals a + 1 and the carry does not leak into cout.
- R7: WIDTH (default 16) and GRP (default 4) set the width and the slice size. Every legal setting gives R1 behaviour, including 8/4 and 64/8, and a WIDTH that is not a whole multiple of GRP is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | WIDTH | First unsigned operand |
| b    | input     | WIDTH | Second unsigned operand |
| cin  | input     | 1     | Carry into the lowest bit |
| sum  | output    | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output    | 1     | Carry out of the most significant slice |

## Verification
The checker assumes that the inputs are two-state and steady whenever its combinational assertions evaluate, because a glitch on a settling input would show up as a spurious mismatch. The bench therefore drives a, b and cin together from tasks and always waits a settling delay before it samples sum and cout. It drives no X or Z values. The stimulus covers every input combination of the 8-bit instance, together with random and boundary patterns on the 16-bit and 64-bit instances.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_GRP   = 4;

    // number of slices for a given width and slice size
    function automatic int unsigned slice_count(input int unsigned w, input int unsigned g);
        return w / g;
    endfunction

    // a width is legal when it is a positive whole multiple of the slice size
    function automatic bit split_ok(input int unsigned w, input int unsigned g);
        return (g != 0) && (w >= g) && ((w % g) == 0);
    endfunction

endpackage

// File: rtl/csel_full_bit.sv
module csel_full_bit (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    assign half = x ^ y;
    assign s    = half ^ ci;
    assign co   = (x & y) | (ci & half);
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csel_full_bit u_fb (
            .x  (x[i]),
            .y  (y[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[W];
endmodule

// File: rtl/csel_plus_one.sv
module csel_plus_one #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] v,
    output logic [W-1:0] v_inc,
    output logic         all_set
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign v_inc[i] = ~v[i];
        end else begin : g_upper
            assign v_inc[i] = v[i] ^ (&v[i-1:0]);
        end
    end

    // a value of all ones wraps to zero when incremented
    assign all_set = &v;
endmodule

// File: rtl/csel_slice.sv
module csel_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W-1:0] s_one;
    logic         wrap;
    logic         c_one;

    csel_ripple #(.W(W)) u_rca (
        .x  (x),
        .y  (y),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    csel_plus_one #(.W(W)) u_inc (
        .v       (s_zero),
        .v_inc   (s_one),
        .all_set (wrap)
    );

    // a zero-carry sum of all ones cannot coexist with c_zero, so OR is exact
    assign c_one = c_zero | wrap;

    always_comb begin
        if (sel) begin
            s  = s_one;
            co = c_one;
        end else begin
            s  = s_zero;
            co = c_zero;
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int unsigned WIDTH = csel_pkg::DEF_WIDTH,
    parameter int unsigned GRP   = csel_pkg::DEF_GRP
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned NSL = csel_pkg::slice_count(WIDTH, GRP);

    if (!csel_pkg::split_ok(WIDTH, GRP)) begin : g_bad_split
        $error("csel_adder: WIDTH must be a whole multiple of GRP");
    end

    logic [NSL:0] link;

    // lowest slice: plain ripple chain fed by the external carry
    csel_ripple #(.W(GRP)) u_low (
        .x  (a[GRP-1:0]),
        .y  (b[GRP-1:0]),
        .ci (cin),
        .s  (sum[GRP-1:0]),
        .co (link[1])
    );

    assign link[0] = cin;

    for (genvar k = 1; k < NSL; k++) begin : g_slice
        csel_slice #(.W(GRP)) u_sl (
            .x   (a[k*GRP +: GRP]),
            .y   (b[k*GRP +: GRP]),
            .sel (link[k]),
            .s   (sum[k*GRP +: GRP]),
            .co  (link[k+1])
        );
    end

    assign cout = link[NSL];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic [WIDTH:0] ref_total;

    always_comb begin
        ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

        // R1
        no_mismatch_chk: assert ({cout, sum} == ref_total)
            else $error("R1 sum mismatch");

        // R3
        if (a == '1 && b == '0 && cin) begin
            wrap_to_zero_chk: assert (sum == '0 && cout)
                else $error("R3 wrap failed");
        end

        // R4
        if (b == ~a && !cin) begin
            complement_ones_chk: assert (sum == '1 && !cout)
                else $error("R4 complement failed");
        end

        // R5
        if (b == '0 && !cin) begin
            zero_identity_chk: assert (sum == a && !cout)
                else $error("R5 identity failed");
        end
    end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/csel_adder_tb.sv
module csel_adder_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] a16, b16, s16;
    logic        c16i, c16o;
    logic [7:0]  a8, b8, s8;
    logic        c8i, c8o;
    logic [63:0] a64, b64, s64;
    logic        c64i, c64o;

    csel_adder u_dut (.a(a16), .b(b16), .cin(c16i), .sum(s16), .cout(c16o));
    csel_adder #(.WIDTH(8),  .GRP(4)) u_dut8  (.a(a8),  .b(b8),  .cin(c8i),  .sum(s8),  .cout(c8o));
    csel_adder #(.WIDTH(64), .GRP(8)) u_dut64 (.a(a64), .b(b64), .cin(c64i), .sum(s64), .cout(c64o));

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive16(input logic [15:0] x, input logic [15:0] y, input logic c);
        a16 = x; b16 = y; c16i = c;
        #(CLK_PERIOD/2);
    endtask

    function automatic logic [16:0] ref16(input logic [15:0] x, input logic [15:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    // R7 R1: exhaustive 8-bit instance
    task automatic t_exhaustive8();
        int bad = 0;
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int c = 0; c < 2; c++) begin
                    a8 = x[7:0]; b8 = y[7:0]; c8i = c[0];
                    #1;
                    if ({c8o, s8} !== 9'(x + y + c)) begin
                        bad++;
                        if (bad < 5)
                            chk("R7 8-bit exhaustive", {56'd0, c8o, s8}, 65'(x + y + c));
                    end
                end
        chk("R7 8-bit exhaustive total", 65'(bad), 65'd0);
    endtask

    // R1: random 16-bit vectors
    task automatic t_random16();
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] x = 16'($urandom);
            logic [15:0] y = 16'($urandom);
            logic        c = 1'($urandom);
            drive16(x, y, c);
            chk("R1 random 16-bit", {48'd0, c16o, s16}, {48'd0, ref16(x, y, c)});
        end
    endtask

    // R2: carry-in adds exactly one
    task automatic t_cin_step();
        for (int i = 0; i < 200; i++) begin
            logic [15:0] x = 16'($urandom);
            logic [15:0] y = 16'($urandom);
            logic [16:0] r0;
            drive16(x, y, 1'b0);
            r0 = {c16o, s16};
            drive16(x, y, 1'b1);
            chk("R2 cin step", {48'd0, c16o, s16}, {48'd0, r0 + 17'd1});
        end
    endtask

    // R3: all ones plus one
    task automatic t_wrap();
        drive16(16'hFFFF, 16'h0000, 1'b1);
        chk("R3 wrap 16-bit", {48'd0, c16o, s16}, {48'd0, 17'h10000});
        drive16(16'h0000, 16'hFFFF, 1'b1);
        chk("R3 wrap swapped", {48'd0, c16o, s16}, {48'd0, 17'h10000});
        a64 = '1; b64 = '0; c64i = 1'b1; #(CLK_PERIOD/2);
        chk("R3 wrap 64-bit", {c64o, s64}, {1'b1, 64'd0});
    endtask

    // R4: complementary operands, alternating patterns
    task automatic t_complement();
        drive16(16'hAAAA, 16'h5555, 1'b0);
        chk("R4 alt AAAA/5555", {48'd0, c16o, s16}, {48'd0, 17'h0FFFF});
        drive16(16'h5555, 16'hAAAA, 1'b1);
        chk("R4 alt cin=1", {48'd0, c16o, s16}, {48'd0, 17'h10000});
        drive16(16'hAAAA, 16'hAAAA, 1'b0);
        chk("R1 alt AAAA+AAAA", {48'd0, c16o, s16}, {48'd0, 17'h15554});
    endtask

    // R5: zero operand identity
    task automatic t_identity();
        drive16(16'hBEEF, 16'h0000, 1'b0);
        chk("R5 identity", {48'd0, c16o, s16}, {48'd0, 17'h0BEEF});
        drive16(16'h0000, 16'h0000, 1'b0);
        chk("R5 zero", {48'd0, c16o, s16}, 65'd0);
    endtask

    // R6: carries crossing slice boundaries
    task automatic t_boundary();
        drive16(16'h000F, 16'h0001, 1'b0);
        chk("R6 slice0->1", {48'd0, c16o, s16}, {48'd0, 17'h00010});
        drive16(16'h00FF, 16'h0001, 1'b0);
        chk("R6 slice1->2", {48'd0, c16o, s16}, {48'd0, 17'h00100});
        drive16(16'h0FFF, 16'h0001, 1'b0);
        chk("R6 slice2->3", {48'd0, c16o, s16}, {48'd0, 17'h01000});
        drive16(16'h0F0F, 16'h0F0F, 1'b0);
        chk("R6 per-slice carry", {48'd0, c16o, s16}, {48'd0, 17'h01E1E});
    endtask

    // R7: 64-bit random vectors with 8-bit slices
    task automatic t_random64();
        for (int i = 0; i < 500; i++) begin
            logic [63:0] x = {$urandom, $urandom};
            logic [63:0] y = {$urandom, $urandom};
            logic        c = 1'($urandom);
            a64 = x; b64 = y; c64i = c;
            #(CLK_PERIOD/2);
            chk("R7 random 64-bit", {c64o, s64}, {1'b0, x} + {1'b0, y} + {64'd0, c});
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; c16i = 1'b0;
        a8 = '0; b8 = '0; c8i = 1'b0;
        a64 = '0; b64 = '0; c64i = 1'b0;
        #(CLK_PERIOD);
        chk("R5 initial zero", {48'd0, c16o, s16}, 65'd0);
        t_identity();
        t_wrap();
        t_complement();
        t_boundary();
        t_cin_step();
        t_random16();
        t_random64();
        t_exhaustive8();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule